// File: doc/BRIEF.md
# Flow signature hash engine

This block turns a 352-bit flow tuple into a bucket index and, optionally, a 16-bit signature. The tuple arrives as eleven 32-bit words. Word 0 carries the flow-type, pool and VLAN fields, and words 1 to 10 carry the addresses, ports and flex bytes. A caller offers a tuple together with two 32-bit keys, a two-bit allocation code and a mode bit through a valid/ready handshake. Some cycles later the block presents one 32-bit hash word for one cycle with `out_valid`.

One multi-cycle datapath is used once per key. The tuple is folded into a high and a low word. The key bits then pick shifted copies of those words, and the copies are XORed into an accumulator. Bits 0 and 16 are taken in one head step. Bits 15..1 and 31..17 follow in a sweep that handles `LANES` bit pairs per cycle. In perfect mode only the bucket pass runs. In signature mode a second pass reruns the fold using the signature key.

The controller has five states:
- `ST_IDLE` accepts a job.
- `ST_FOLD` loads the folded words and clears the accumulator.
- `ST_HEAD` applies key bits 0 and 16, then mixes word 0 into the low word.
- `ST_SWEEP` runs the remaining bit pairs.
- `ST_EMIT` presents the result.

The transitions are:
- IDLE→FOLD on an accepted input.
- FOLD→HEAD and HEAD→SWEEP unconditionally.
- SWEEP→SWEEP while bit pairs remain.
- SWEEP→FOLD at the end of the bucket pass in signature mode.
- SWEEP→EMIT otherwise.
- EMIT→IDLE unconditionally.

Top module: `flow_sig_hash`

## Requirements
- R1: `in_ready` is 1 only while the block is idle. A job is taken on a rising edge where `in_valid` and `in_ready` are both 1, and `in_ready` stays 0 from that edge until the result has been presented.
- R2: An `in_valid` pulse while `in_ready` is 0 is ignored. It produces no extra result and does not change the result of the job in flight.
- R3: With w0 as word 0 and C as the XOR of words 1..10, the high word is C ^ w0 ^ (w0 >> 16) and the initial low word is C with its 16-bit halves swapped. Key bit 16 XORs the high word into the accumulator.
- R4: Key bit 0 XORs the initial low word (before any word-0 mixing) into the accumulator. Afterwards the low word becomes itself ^ w0 ^ (w0 << 16).
- R5: For i = 15 down to 1, key bit i XORs (low >> i) into the accumulator and key bit 16+i XORs (high >> i) into it.
- R6: Perfect mode (`in_sig_mode`=0): bits 31:16 of `out_hash` are 0 and bits 15:0 hold the bucket-key accumulator masked to 11, 12 or 13 bits for allocation codes 01, 10 and 11. Code 00 masks like 01.
- R7: Signature mode (`in_sig_mode`=1): bits 15:0 hold the bucket-key accumulator masked to 13, 14 or 15 bits for codes 01, 10 and 11 (00 as 01). Bits 31:16 hold bits 15:0 of the accumulator computed with `in_sig_key`.
- R8: The accumulator starts from zero for every pass, so back-to-back identical jobs give identical results.
- R9: With S = 15/LANES, `out_valid` is 1 for exactly one cycle. It follows the accepting edge by S+2 rising edges in perfect mode and by 2S+4 in signature mode.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Job offered |
| in_ready | output | 1 | Block idle, job will be taken |
| in_tuple | input | 352 | Flow tuple, word k at bits 32k+31:32k |
| in_bucket_key | input | 32 | Key for the bucket pass |
| in_sig_key | input | 32 | Key for the signature pass |
| in_alloc | input | 2 | Allocation code 00/01/10/11 |
| in_sig_mode | input | 1 | 1 = signature mode, 0 = perfect mode |
| out_valid | output | 1 | Result valid, one cycle |
| out_hash | output | 32 | Packed result |

## Verification
The bench builds two copies of the block that share the same stimulus. One uses `LANES`=1, giving a fifteen-cycle sweep where the per-bit shift indexing and the loop-exit condition do the most work. The other uses `LANES`=5, giving a three-cycle sweep where several lanes sit at different shift distances in the same cycle and the last-step test falls on a non-unit stride. Both are checked against one reference, under their own latency formulas. The sparse-tuple cases isolate key bits 0, 1 and 16 so that the ordering of the word-0 mixing is observable at the output.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
    localparam int unsigned WORD_W         = 32;
    localparam int unsigned TUPLE_WORDS    = 11;
    localparam int unsigned HALF_W         = WORD_W / 2;
    localparam int unsigned TUPLE_W        = WORD_W * TUPLE_WORDS;
    localparam int unsigned IDX_W          = $clog2(HALF_W);
    localparam int unsigned PERFECT_BASE_W = 11;
    localparam int unsigned SIG_BASE_W     = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FOLD,
        ST_HEAD,
        ST_SWEEP,
        ST_EMIT
    } fsh_state_e;

    function automatic logic [WORD_W-1:0] swap_halves(input logic [WORD_W-1:0] w);
        return {w[HALF_W-1:0], w[WORD_W-1:HALF_W]};
    endfunction
endpackage

// File: rtl/fsh_fold.sv
module fsh_fold
    import fsh_pkg::*;
#(
    parameter int unsigned W = WORD_W,
    parameter int unsigned N = TUPLE_WORDS
) (
    input  logic [W*N-1:0] tuple_i,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o,
    output logic [W-1:0]   lo_late_o
);
    localparam int unsigned H = W / 2;

    logic [W-1:0] common;
    logic [W-1:0] w0;

    assign w0 = tuple_i[W-1:0];

    // R3: XOR of the address/port words
    always_comb begin
        common = '0;
        for (int n = 1; n < int'(N); n++) begin
            common = common ^ tuple_i[n*W +: W];
        end
    end

    assign hi_o      = common ^ w0 ^ (w0 >> H);
    assign lo_o      = swap_halves(common);
    // R4: applied to the low word only after key bit 0
    assign lo_late_o = w0 ^ (w0 << H);
endmodule

// File: rtl/fsh_sweep.sv
module fsh_sweep
    import fsh_pkg::*;
#(
    parameter int unsigned W     = WORD_W,
    parameter int unsigned LANES = 1,
    parameter int unsigned IW    = IDX_W
) (
    input  logic [W-1:0]  acc_i,
    input  logic [W-1:0]  hi_i,
    input  logic [W-1:0]  lo_i,
    input  logic [W-1:0]  key_i,
    input  logic [IW-1:0] idx_i,
    output logic [W-1:0]  acc_o
);
    localparam int unsigned H = W / 2;

    logic [H-1:0] key_lo;
    logic [H-1:0] key_hi;
    logic [W-1:0] terms [LANES];

    assign key_lo = key_i[H-1:0];
    assign key_hi = key_i[W-1:H];

    // R5: one bit pair per lane, lane j at shift idx-j
    for (genvar j = 0; j < int'(LANES); j++) begin : g_lane
        logic [IW-1:0] sh;
        assign sh       = idx_i - IW'(j);
        assign terms[j] = (key_lo[sh] ? (lo_i >> sh) : '0)
                        ^ (key_hi[sh] ? (hi_i >> sh) : '0);
    end

    always_comb begin
        acc_o = acc_i;
        for (int j = 0; j < int'(LANES); j++) begin
            acc_o = acc_o ^ terms[j];
        end
    end
endmodule

// File: rtl/fsh_bucket_mask.sv
module fsh_bucket_mask
    import fsh_pkg::*;
#(
    parameter int unsigned W      = WORD_W,
    parameter int unsigned BASE_P = PERFECT_BASE_W,
    parameter int unsigned BASE_S = SIG_BASE_W
) (
    input  logic [W-1:0]   hash_i,
    input  logic [1:0]     alloc_i,
    input  logic           sig_mode_i,
    output logic [W/2-1:0] bucket_o
);
    localparam int unsigned H = W / 2;

    int unsigned step;
    int unsigned width;
    logic [H-1:0] mask;

    // R6/R7: code 00 falls back to the smallest allocation
    always_comb begin
        unique case (alloc_i)
            2'b10:   step = 1;
            2'b11:   step = 2;
            default: step = 0;
        endcase
        width    = (sig_mode_i ? BASE_S : BASE_P) + step;
        mask     = ~({H{1'b1}} << width);
        bucket_o = hash_i[H-1:0] & mask;
    end
endmodule

// File: rtl/flow_sig_hash.sv
module flow_sig_hash
    import fsh_pkg::*;
#(
    parameter int unsigned LANES = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [TUPLE_W-1:0] in_tuple,
    input  logic [WORD_W-1:0]  in_bucket_key,
    input  logic [WORD_W-1:0]  in_sig_key,
    input  logic [1:0]         in_alloc,
    input  logic               in_sig_mode,
    output logic               out_valid,
    output logic [WORD_W-1:0]  out_hash
);
    localparam int unsigned SWEEP_STEPS = (HALF_W - 1) / LANES;
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(HALF_W - 1);
    localparam logic [IDX_W-1:0] IDX_STEP = IDX_W'(LANES);

    fsh_state_e state_q, state_d;

    logic [TUPLE_W-1:0] tup_q;
    logic [WORD_W-1:0]  bkey_q, skey_q;
    logic [1:0]         alloc_q;
    logic               sig_mode_q;
    logic               pass_sig_q;
    logic [WORD_W-1:0]  hi_q, lo_q, acc_q;
    logic [IDX_W-1:0]   idx_q;
    logic [HALF_W-1:0]  bucket_q;
    logic [WORD_W-1:0]  result_q;

    logic [WORD_W-1:0]  fold_hi, fold_lo, fold_late;
    logic [WORD_W-1:0]  key_now;
    logic [WORD_W-1:0]  sweep_acc;
    logic [HALF_W-1:0]  bucket_w;
    logic               last_step;

    assign key_now   = pass_sig_q ? skey_q : bkey_q;
    assign last_step = (idx_q == IDX_STEP);

    fsh_fold #(.W(WORD_W), .N(TUPLE_WORDS)) u_fold (
        .tuple_i   (tup_q),
        .hi_o      (fold_hi),
        .lo_o      (fold_lo),
        .lo_late_o (fold_late)
    );

    fsh_sweep #(.W(WORD_W), .LANES(LANES), .IW(IDX_W)) u_sweep (
        .acc_i (acc_q),
        .hi_i  (hi_q),
        .lo_i  (lo_q),
        .key_i (key_now),
        .idx_i (idx_q),
        .acc_o (sweep_acc)
    );

    fsh_bucket_mask #(.W(WORD_W), .BASE_P(PERFECT_BASE_W), .BASE_S(SIG_BASE_W)) u_mask (
        .hash_i     (sweep_acc),
        .alloc_i    (alloc_q),
        .sig_mode_i (sig_mode_q),
        .bucket_o   (bucket_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = ST_FOLD;
            ST_FOLD:  state_d = ST_HEAD;
            ST_HEAD:  state_d = ST_SWEEP;
            ST_SWEEP: if (last_step) state_d = (sig_mode_q && !pass_sig_q) ? ST_FOLD : ST_EMIT;
            ST_EMIT:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_EMIT);
        out_hash  = result_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tup_q      <= '0;
            bkey_q     <= '0;
            skey_q     <= '0;
            alloc_q    <= '0;
            sig_mode_q <= 1'b0;
            pass_sig_q <= 1'b0;
            hi_q       <= '0;
            lo_q       <= '0;
            acc_q      <= '0;
            idx_q      <= '0;
            bucket_q   <= '0;
            result_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        tup_q      <= in_tuple;
                        bkey_q     <= in_bucket_key;
                        skey_q     <= in_sig_key;
                        alloc_q    <= in_alloc;
                        sig_mode_q <= in_sig_mode;
                        pass_sig_q <= 1'b0;
                    end
                end
                ST_FOLD: begin
                    hi_q  <= fold_hi;
                    lo_q  <= fold_lo;
                    acc_q <= '0;
                end
                ST_HEAD: begin
                    acc_q <= (key_now[0] ? lo_q : '0) ^ (key_now[HALF_W] ? hi_q : '0);
                    lo_q  <= lo_q ^ fold_late;
                    idx_q <= IDX_TOP;
                end
                ST_SWEEP: begin
                    acc_q <= sweep_acc;
                    idx_q <= idx_q - IDX_STEP;
                    if (last_step) begin
                        if (sig_mode_q && !pass_sig_q) begin
                            bucket_q   <= bucket_w;
                            pass_sig_q <= 1'b1;
                        end else if (!sig_mode_q) begin
                            result_q <= {{HALF_W{1'b0}}, bucket_w};
                        end else begin
                            result_q <= {sweep_acc[HALF_W-1:0], bucket_q};
                        end
                    end
                end
                ST_EMIT: ;
                default: ;
            endcase
        end
    end

    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_tuple_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(tup_q));

    assert_sweep_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP) |-> (idx_q >= IDX_STEP && idx_q <= IDX_TOP));

    assert_perfect_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sig_mode_q) |-> (out_hash[WORD_W-1:HALF_W] == '0));

    assert_bucket_msb_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hash[HALF_W-1] == 1'b0));

    assert_acc_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FOLD) |=> (acc_q == '0));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    initial begin
        assert_steps_nonzero_R9: assert (SWEEP_STEPS * LANES == HALF_W - 1);
    end
endmodule

// File: tb/test_flow_sig_hash.sv
module test_flow_sig_hash;
    import fsh_pkg::*;

    localparam int unsigned SLOW_LANES = 1;
    localparam int unsigned FAST_LANES = 5;
    localparam int SLOW_S = 15 / SLOW_LANES;
    localparam int FAST_S = 15 / FAST_LANES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic               in_valid = 1'b0;
    logic [TUPLE_W-1:0] in_tuple = '0;
    logic [31:0]        in_bucket_key = '0;
    logic [31:0]        in_sig_key = '0;
    logic [1:0]         in_alloc = '0;
    logic               in_sig_mode = 1'b0;

    logic        a_ready, a_valid, b_ready, b_valid;
    logic [31:0] a_hash, b_hash;

    flow_sig_hash #(.LANES(SLOW_LANES)) i_flow_sig_hash (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_ready),
        .in_tuple(in_tuple), .in_bucket_key(in_bucket_key), .in_sig_key(in_sig_key),
        .in_alloc(in_alloc), .in_sig_mode(in_sig_mode),
        .out_valid(a_valid), .out_hash(a_hash));

    flow_sig_hash #(.LANES(FAST_LANES)) i_flow_sig_hash_fast (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(b_ready),
        .in_tuple(in_tuple), .in_bucket_key(in_bucket_key), .in_sig_key(in_sig_key),
        .in_alloc(in_alloc), .in_sig_mode(in_sig_mode),
        .out_valid(b_valid), .out_hash(b_hash));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] exp_a[$], exp_b[$];
    int          acc_a[$], acc_b[$], lat_a[$], lat_b[$];
    string       tag_a[$], tag_b[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference accumulator, R3/R4/R5
    function automatic logic [31:0] ref_acc(input logic [TUPLE_W-1:0] t, input logic [31:0] k);
        logic [31:0] w0, com, hi, lo, acc;
        w0 = t[31:0];
        com = '0;
        for (int n = 1; n < 11; n++) com ^= t[32*n +: 32];
        hi = com ^ w0 ^ (w0 >> 16);
        lo = {com[15:0], com[31:16]};
        acc = '0;
        if (k[0])  acc ^= lo;
        if (k[16]) acc ^= hi;
        lo ^= w0 ^ (w0 << 16);
        for (int i = 15; i >= 1; i--) begin
            if (k[i])      acc ^= lo >> i;
            if (k[16 + i]) acc ^= hi >> i;
        end
        return acc;
    endfunction

    // R6/R7 packing
    function automatic logic [31:0] ref_out(input logic [TUPLE_W-1:0] t, input logic [31:0] bk,
                                            input logic [31:0] sk, input logic [1:0] al, input logic md);
        int w;
        logic [15:0] bkt;
        case (al)
            2'b10:   w = md ? 14 : 12;
            2'b11:   w = md ? 15 : 13;
            default: w = md ? 13 : 11;
        endcase
        bkt = ref_acc(t, bk)[15:0] & 16'((32'h1 << w) - 1);
        if (md) return {ref_acc(t, sk)[15:0], bkt};
        return {16'h0, bkt};
    endfunction

    always @(negedge clk) begin
        if (rst_n && a_valid) begin
            if (exp_a.size() == 0) check(1'b0, "R2 extra result slow", a_hash, 32'h0);
            else begin
                check(a_hash == exp_a[0], tag_a[0], a_hash, exp_a[0]);
                check(cyc - acc_a[0] == lat_a[0], "R9 latency slow", 32'(cyc - acc_a[0]), 32'(lat_a[0]));
                void'(exp_a.pop_front()); void'(acc_a.pop_front());
                void'(lat_a.pop_front()); void'(tag_a.pop_front());
            end
        end
        if (rst_n && b_valid) begin
            if (exp_b.size() == 0) check(1'b0, "R2 extra result fast", b_hash, 32'h0);
            else begin
                check(b_hash == exp_b[0], tag_b[0], b_hash, exp_b[0]);
                check(cyc - acc_b[0] == lat_b[0], "R9 latency fast", 32'(cyc - acc_b[0]), 32'(lat_b[0]));
                void'(exp_b.pop_front()); void'(acc_b.pop_front());
                void'(lat_b.pop_front()); void'(tag_b.pop_front());
            end
        end
    end

    task automatic run_job(input logic [TUPLE_W-1:0] t, input logic [31:0] bk, input logic [31:0] sk,
                           input logic [1:0] al, input logic md, input string tag, input bit noise);
        logic [31:0] e;
        while (!(a_ready && b_ready)) @(negedge clk);
        in_tuple = t; in_bucket_key = bk; in_sig_key = sk; in_alloc = al; in_sig_mode = md;
        in_valid = 1'b1;
        e = ref_out(t, bk, sk, al, md);
        exp_a.push_back(e); acc_a.push_back(cyc + 1); tag_a.push_back(tag);
        lat_a.push_back(md ? 2*SLOW_S + 4 : SLOW_S + 2);
        exp_b.push_back(e); acc_b.push_back(cyc + 1); tag_b.push_back(tag);
        lat_b.push_back(md ? 2*FAST_S + 4 : FAST_S + 2);
        @(negedge clk);
        in_valid = 1'b0;
        if (noise) begin
            for (int n = 0; n < 3; n++) begin
                check(!a_ready && !b_ready, "R1 ready low while busy", {30'h0, a_ready, b_ready}, 32'h0);
                in_tuple = ~t; in_bucket_key = ~bk; in_sig_key = ~sk; in_alloc = ~al; in_sig_mode = ~md;
                in_valid = 1'b1;
                @(negedge clk);
            end
            in_valid = 1'b0;
        end
    endtask

    function automatic logic [TUPLE_W-1:0] rand_tuple();
        logic [TUPLE_W-1:0] t;
        for (int n = 0; n < 11; n++) t[32*n +: 32] = $urandom;
        return t;
    endfunction

    localparam logic [31:0] KB = 32'h5A3C96E1;
    localparam logic [31:0] KS = 32'h1F2E3D4C;

    initial begin
        fork
            begin
                logic [TUPLE_W-1:0] t;
                repeat (3) @(negedge clk);
                check(a_valid == 1'b0, "R10 out_valid slow in reset", {31'h0, a_valid}, 32'h0);
                check(b_valid == 1'b0, "R10 out_valid fast in reset", {31'h0, b_valid}, 32'h0);
                rst_n = 1'b1;
                @(negedge clk);
                check(a_ready == 1'b1, "R10 in_ready slow", {31'h0, a_ready}, 32'h1);
                check(b_ready == 1'b1, "R10 in_ready fast", {31'h0, b_ready}, 32'h1);

                run_job('0, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'b01, 1'b0, "R3 zero tuple", 1'b0);
                t = '0; t[31:0] = 32'hABCD1234;
                run_job(t, 32'h00000001, 32'h00000001, 2'b11, 1'b1, "R4 bit0 before word0 mix", 1'b0);
                run_job(t, 32'h00010000, 32'h0, 2'b11, 1'b0, "R3 bit16 high word", 1'b0);
                run_job(t, 32'h00000002, 32'h00020000, 2'b10, 1'b1, "R4 bit1 after word0 mix", 1'b0);
                t[32 +: 32] = 32'h0F0F3C3C;
                run_job(t, 32'h80008000, 32'h40014001, 2'b11, 1'b1, "R5 top bit pairs", 1'b0);
                for (int al = 0; al < 4; al++) begin
                    t = rand_tuple();
                    run_job(t, KB, KS, 2'(al), 1'b0, "R6 perfect alloc", 1'b0);
                    run_job(t, KB, KS, 2'(al), 1'b1, "R7 signature alloc", 1'b0);
                end
                t = rand_tuple();
                run_job(t, KB, KS, 2'b11, 1'b1, "R8 repeat first", 1'b0);
                run_job(t, KB, KS, 2'b11, 1'b1, "R8 repeat second", 1'b0);
                run_job(rand_tuple(), KB, KS, 2'b10, 1'b0, "R2 noise perfect", 1'b1);
                run_job(rand_tuple(), KB, KS, 2'b01, 1'b1, "R2 noise signature", 1'b1);
                for (int n = 0; n < 6; n++)
                    run_job(rand_tuple(), $urandom, $urandom, 2'($urandom), 1'($urandom), "R5 random", 1'b0);
                while (exp_a.size() != 0 || exp_b.size() != 0) @(negedge clk);
                repeat (5) @(negedge clk);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL R9 watchdog: actual hung expected done");
            end
        join_any
        check(exp_a.size() == 0 && exp_b.size() == 0, "R9 all results produced",
              32'(exp_a.size() + exp_b.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule